// File: doc/BRIEF.md
# Auto-Address-Increment Word Program Sequencer

This block runs the word-at-a-time programming mode of a serial flash device. An upstream SPI front end decodes each command and, when chip select rises at the end of the command, presents one strobe with the opcode, the 24-bit address and the two data bytes. The sequencer turns each accepted word into two consecutive byte writes on an array program port, holds a busy flag for a parameterised number of clocks that stands in for the physical programming time, and keeps the mode and write-enable status bits that the status-register reader shows.

Programming opens with an entry command that carries a start address. After that, each continuation command carries only data, and the word address advances by two on its own. The mode has no wrap-around. It closes on a disable-write command, or by itself once the word just programmed reaches the last address below the protected region. That region's lower bound comes from a separate protection unit. While chip select is low in this mode, an optional ready/busy level can be driven on the serial output.

Top module: `aai_seq`

## Requirements
- R1: After reset the status byte is 0x00, no byte write is issued and the serial output is not driven.
- R2: Opcode 0x06 sets the write-enable bit (status bit 1) and opcode 0x04 clears it. An entry command (opcode 0xAD outside the mode) is accepted only while write-enable is 1. Acceptance sets the mode bit (status bit 6).
- R3: An accepted entry writes the first data byte to the start address with bit 0 forced to 0, in the cycle after the strobe. It writes the second data byte to the same address with bit 0 set to 1 in the next cycle.
- R4: In the mode, opcode 0xAD is a continuation: it ignores its address field and writes its two bytes to the word that follows the previous one (address plus 2).
- R5: Busy (status bit 0) rises in the cycle after an accepted word strobe and stays high for BUSY_CYC+2 cycles. Byte writes occur only while busy is high.
- R6: Any command strobed while busy is high is dropped and changes no state.
- R7: In the mode, only opcodes 0xAD, 0x04 and 0x05 are acted on. Opcodes 0x06, 0x70, 0x80 and all others are ignored.
- R8: Opcode 0x04 in the mode clears both the mode bit and write-enable. A later 0xAD is then ignored unless write-enable is set again.
- R9: When a word ends at or past the last address below the protection bound, or at the top of the address space, the mode and write-enable bits clear as busy falls. No further write occurs, and the address does not wrap.
- R10: An entry whose forced-even start address is at or above the protection bound is ignored: no write, the mode stays off, write-enable stays 1.
- R11: A byte whose address is at or above the protection bound is never written, even when the other byte of the same word is.
- R12: Opcode 0x70 (outside the mode) enables ready/busy output and 0x80 (outside the mode) disables it. When it is enabled, the mode is on and chip select is low, the output is driven with 0 while busy and 1 while ready. It is not driven while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select level, low = selected |
| cmd_stb_i | input | 1 | One-cycle strobe: a decoded command completed |
| cmd_op_i | input | 8 | Decoded opcode |
| cmd_addr_i | input | ADDR_W | Address field of the command |
| cmd_dlo_i | input | 8 | First data byte |
| cmd_dhi_i | input | 8 | Second data byte |
| prot_base_i | input | ADDR_W+1 | First protected address; 2**ADDR_W means none protected |
| pgm_we_o | output | 1 | Array byte write strobe |
| pgm_addr_o | output | ADDR_W | Array byte address |
| pgm_data_o | output | 8 | Array byte data |
| stat_o | output | 8 | Status bits: 0 busy, 1 write-enable, 6 mode, others 0 |
| so_oe_o | output | 1 | Serial output driven with ready/busy level |
| so_o | output | 1 | Ready/busy level, 1 = ready |

## Verification
The checks assume that the front end strobes a command only in a cycle where chip select is high or rising. They also assume the protection bound does not move while the mode is active: the no-wrap and write-gating properties compare addresses with the bound as it stands now. The stimulus meets both assumptions. Each command is strobed together with the chip-select rise, and a new bound is picked at random only while the bench model shows the mode off. Apart from this, random opcodes, addresses near and above the bound, and back-to-back commands sent into a busy window are allowed.

// File: rtl/aai_seq_pkg.sv
package aai_seq_pkg;
   localparam logic [7:0] OP_WORD   = 8'hAD;
   localparam logic [7:0] OP_WDIS   = 8'h04;
   localparam logic [7:0] OP_WEN    = 8'h06;
   localparam logic [7:0] OP_STAT   = 8'h05;
   localparam logic [7:0] OP_RB_ON  = 8'h70;
   localparam logic [7:0] OP_RB_OFF = 8'h80;

   localparam int ST_BUSY = 0;
   localparam int ST_WEL  = 1;
   localparam int ST_MODE = 6;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_LO,
      ENG_HI,
      ENG_HOLD
   } eng_state_e;

   typedef struct packed {
      logic enter;
      logic word;
      logic wdis;
      logic wen;
      logic rb_on;
      logic rb_off;
   } cmd_act_t;
endpackage

// File: rtl/aai_cmd_filter.sv
module aai_cmd_filter
   import aai_seq_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic              cmd_stb_i,
   input  logic [7:0]        cmd_op_i,
   input  logic [ADDR_W-2:0] start_word_i,
   input  logic [ADDR_W:0]   prot_base_i,
   input  logic              busy_i,
   input  logic              mode_i,
   input  logic              wel_i,
   output cmd_act_t          act_o
);
   localparam int AW1 = ADDR_W + 1;

   logic live;
   logic start_ok;

   // Commands arriving during a program cycle are dropped (status reads need no action)
   assign live     = cmd_stb_i && !busy_i;
   assign start_ok = AW1'({start_word_i, 1'b0}) < prot_base_i;

   always_comb begin
      act_o = '0;
      if (live) begin
         if (mode_i) begin
            act_o.word = (cmd_op_i == OP_WORD);
            act_o.wdis = (cmd_op_i == OP_WDIS);
         end else begin
            act_o.enter  = (cmd_op_i == OP_WORD) && wel_i && start_ok;
            act_o.wdis   = (cmd_op_i == OP_WDIS);
            act_o.wen    = (cmd_op_i == OP_WEN);
            act_o.rb_on  = (cmd_op_i == OP_RB_ON);
            act_o.rb_off = (cmd_op_i == OP_RB_OFF);
         end
      end
   end
endmodule

// File: rtl/aai_mode_regs.sv
module aai_mode_regs
   import aai_seq_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  cmd_act_t act_i,
   input  logic     word_done_i,
   input  logic     word_last_i,
   output logic     mode_o,
   output logic     wel_o,
   output logic     rb_en_o
);
   logic auto_exit;
   assign auto_exit = word_done_i && word_last_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_o  <= 1'b0;
         wel_o   <= 1'b0;
         rb_en_o <= 1'b0;
      end else begin
         if (act_i.wdis || auto_exit) begin
            mode_o <= 1'b0;
            wel_o  <= 1'b0;
         end else begin
            if (act_i.enter) mode_o <= 1'b1;
            if (act_i.wen)   wel_o  <= 1'b1;
         end
         if (act_i.rb_on)       rb_en_o <= 1'b1;
         else if (act_i.rb_off) rb_en_o <= 1'b0;
      end
   end
endmodule

// File: rtl/aai_word_engine.sv
module aai_word_engine
   import aai_seq_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 8,
   parameter int BUSY_CYC = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  cmd_act_t          act_i,
   input  logic [ADDR_W-2:0] start_word_i,
   input  logic [DATA_W-1:0] dlo_i,
   input  logic [DATA_W-1:0] dhi_i,
   input  logic [ADDR_W:0]   prot_base_i,
   output logic              busy_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              word_done_o,
   output logic              word_last_o
);
   localparam int AW1   = ADDR_W + 1;
   localparam int CNT_W = $clog2(BUSY_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC - 1);

   eng_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-2:0] word_q;
   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] hi_q;
   logic              lo_ok;
   logic              hi_ok;
   logic              start;

   assign start       = act_i.enter || act_i.word;
   assign lo_ok       = AW1'({word_q, 1'b0}) < prot_base_i;
   assign hi_ok       = AW1'({word_q, 1'b1}) < prot_base_i;
   assign word_last_o = (AW1'({word_q, 1'b0}) + AW1'(2)) >= prot_base_i;
   assign word_done_o = (state_q == ENG_HOLD) && (cnt_q == '0);
   assign busy_o      = (state_q != ENG_IDLE);

   always_comb begin
      we_o   = 1'b0;
      addr_o = {word_q, 1'b0};
      data_o = lo_q;
      unique case (state_q)
         ENG_LO: we_o = lo_ok;
         ENG_HI: begin
            we_o   = hi_ok;
            addr_o = {word_q, 1'b1};
            data_o = hi_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ENG_IDLE;
         cnt_q   <= '0;
         word_q  <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else begin
         unique case (state_q)
            ENG_IDLE: if (start) begin
               state_q <= ENG_LO;
               lo_q    <= dlo_i;
               hi_q    <= dhi_i;
               if (act_i.enter) word_q <= start_word_i;
            end
            ENG_LO: state_q <= ENG_HI;
            ENG_HI: begin
               state_q <= ENG_HOLD;
               cnt_q   <= CNT_LOAD;
            end
            ENG_HOLD: begin
               if (cnt_q == '0) begin
                  state_q <= ENG_IDLE;
                  if (!word_last_o) word_q <= word_q + 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/aai_so_driver.sv
module aai_so_driver #(
   parameter bit SO_REG = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cs_ni,
   input  logic rb_en_i,
   input  logic mode_i,
   input  logic busy_i,
   output logic so_oe_o,
   output logic so_o
);
   logic oe_d;
   logic lvl_d;

   assign oe_d  = !cs_ni && rb_en_i && mode_i;
   assign lvl_d = !busy_i;

   generate
      if (SO_REG) begin : g_reg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               so_oe_o <= 1'b0;
               so_o    <= 1'b1;
            end else begin
               so_oe_o <= oe_d && !cs_ni;
               so_o    <= lvl_d;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk_i ^ rst_ni;
         assign so_oe_o    = oe_d;
         assign so_o       = lvl_d;
      end
   endgenerate
endmodule

// File: rtl/aai_seq.sv
module aai_seq
   import aai_seq_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int DATA_W   = 8,
   parameter int BUSY_CYC = 6,
   parameter bit SO_REG   = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cs_ni,
   input  logic              cmd_stb_i,
   input  logic [7:0]        cmd_op_i,
   input  logic [ADDR_W-1:0] cmd_addr_i,
   input  logic [DATA_W-1:0] cmd_dlo_i,
   input  logic [DATA_W-1:0] cmd_dhi_i,
   input  logic [ADDR_W:0]   prot_base_i,
   output logic              pgm_we_o,
   output logic [ADDR_W-1:0] pgm_addr_o,
   output logic [DATA_W-1:0] pgm_data_o,
   output logic [7:0]        stat_o,
   output logic              so_oe_o,
   output logic              so_o
);
   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr
      $error("aai_seq: ADDR_W out of range");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("aai_seq: BUSY_CYC must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("aai_seq: DATA_W must be positive");
   end

   cmd_act_t act;
   logic     busy;
   logic     mode;
   logic     wel;
   logic     rb_en;
   logic     word_done;
   logic     word_last;
   logic     unused_a0;

   // Address bit 0 is forced low on entry
   assign unused_a0 = cmd_addr_i[0];

   aai_cmd_filter #(.ADDR_W(ADDR_W)) filt_i (
      .cmd_stb_i   (cmd_stb_i),
      .cmd_op_i    (cmd_op_i),
      .start_word_i(cmd_addr_i[ADDR_W-1:1]),
      .prot_base_i (prot_base_i),
      .busy_i      (busy),
      .mode_i      (mode),
      .wel_i       (wel),
      .act_o       (act)
   );

   aai_mode_regs mode_i_ (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (act),
      .word_done_i(word_done),
      .word_last_i(word_last),
      .mode_o     (mode),
      .wel_o      (wel),
      .rb_en_o    (rb_en)
   );

   aai_word_engine #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .BUSY_CYC(BUSY_CYC)
   ) eng_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .act_i       (act),
      .start_word_i(cmd_addr_i[ADDR_W-1:1]),
      .dlo_i       (cmd_dlo_i),
      .dhi_i       (cmd_dhi_i),
      .prot_base_i (prot_base_i),
      .busy_o      (busy),
      .we_o        (pgm_we_o),
      .addr_o      (pgm_addr_o),
      .data_o      (pgm_data_o),
      .word_done_o (word_done),
      .word_last_o (word_last)
   );

   aai_so_driver #(.SO_REG(SO_REG)) so_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cs_ni  (cs_ni),
      .rb_en_i(rb_en),
      .mode_i (mode),
      .busy_i (busy),
      .so_oe_o(so_oe_o),
      .so_o   (so_o)
   );

   always_comb begin
      stat_o          = '0;
      stat_o[ST_BUSY] = busy;
      stat_o[ST_WEL]  = wel;
      stat_o[ST_MODE] = mode;
   end
endmodule

// File: rtl/aai_seq_chk.sv
module aai_seq_chk #(
   parameter int ADDR_W = 24
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              cs_ni,
   input logic [7:0]        stat_o,
   input logic              pgm_we_o,
   input logic [ADDR_W-1:0] pgm_addr_o,
   input logic [ADDR_W:0]   prot_base_i,
   input logic              so_oe_o
);
   logic past_ok;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) past_ok <= 1'b0;
      else         past_ok <= 1'b1;
   end

   AST_WE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pgm_we_o |-> stat_o[0]); // R5
   AST_WE_IN_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pgm_we_o |-> stat_o[6]); // R3
   AST_HI_NOT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && pgm_we_o && pgm_addr_o[0] |-> $past(stat_o[0])); // R3
   AST_MODE_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_o[6] |-> stat_o[1]); // R2
   AST_ENTRY_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $rose(stat_o[6]) |-> $past(stat_o[1])); // R2
   AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && stat_o[0] && $past(stat_o[0]) |-> $stable(stat_o[6]) && $stable(stat_o[1])); // R6
   AST_NO_PROT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pgm_we_o |-> ({1'b0, pgm_addr_o} < prot_base_i)); // R11
   AST_SO_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && cs_ni && $past(cs_ni) |-> !so_oe_o); // R12
endmodule

bind aai_seq aai_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .cs_ni      (cs_ni),
   .stat_o     (stat_o),
   .pgm_we_o   (pgm_we_o),
   .pgm_addr_o (pgm_addr_o),
   .prot_base_i(prot_base_i),
   .so_oe_o    (so_oe_o)
);

// File: tb/aai_seq_tb_top.sv
module aai_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;
   localparam int BC = 6;
   localparam logic [AW:0] PB_NONE = 25'h1000000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          stb = 1'b0;
   logic [7:0]    op = '0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    dlo = '0;
   logic [7:0]    dhi = '0;
   logic [AW:0]   pb = PB_NONE;
   logic          we;
   logic [AW-1:0] waddr;
   logic [7:0]    wdata;
   logic [7:0]    stat;
   logic          so_oe;
   logic          so;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model
   bit            m_mode = 0, m_wel = 0, m_rb = 0;
   logic [AW:0]   m_addr = '0;
   logic [AW:0]   eq_a[$];
   logic [7:0]    eq_d[$];
   logic [AW:0]   gq_a[$];
   logic [7:0]    gq_d[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   aai_seq #(.ADDR_W(AW), .DATA_W(8), .BUSY_CYC(BC)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .cmd_stb_i(stb), .cmd_op_i(op),
      .cmd_addr_i(addr), .cmd_dlo_i(dlo), .cmd_dhi_i(dhi), .prot_base_i(pb),
      .pgm_we_o(we), .pgm_addr_o(waddr), .pgm_data_o(wdata), .stat_o(stat),
      .so_oe_o(so_oe), .so_o(so)
   );

   always @(negedge clk) if (we) begin
      gq_a.push_back({1'b0, waddr});
      gq_d.push_back(wdata);
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_stat(bit busy);
      return {1'b0, m_mode, 4'b0, m_wel, busy};
   endfunction

   task automatic m_word();
      if (m_addr < pb) begin eq_a.push_back(m_addr); eq_d.push_back(dlo); end
      if ((m_addr | 1) < pb) begin eq_a.push_back(m_addr | 1); eq_d.push_back(dhi); end
      if (m_addr + 2 >= pb) begin m_mode = 0; m_wel = 0; end
      else m_addr = m_addr + 2;
   endtask

   // model of a command completing while the sequencer is idle
   task automatic m_apply();
      logic [AW:0] s;
      s = {1'b0, addr[AW-1:1], 1'b0};
      if (m_mode) begin
         if (op == 8'hAD) m_word();
         else if (op == 8'h04) begin m_mode = 0; m_wel = 0; end
      end else begin
         case (op)
            8'hAD: if (m_wel && s < pb) begin m_mode = 1; m_addr = s; m_word(); end
            8'h04: m_wel = 0;
            8'h06: m_wel = 1;
            8'h70: m_rb = 1;
            8'h80: m_rb = 0;
            default: ;
         endcase
      end
   endtask

   task automatic send_raw(logic [7:0] o, logic [AW-1:0] a, logic [7:0] l, logic [7:0] h);
      @(negedge clk);
      cs_n = 1'b0;
      repeat (2) @(negedge clk);
      op = o; addr = a; dlo = l; dhi = h;
      stb = 1'b1; cs_n = 1'b1;
      @(negedge clk);
      stb = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (BC + 3) @(negedge clk);
   endtask

   task automatic send(logic [7:0] o, logic [AW-1:0] a, logic [7:0] l, logic [7:0] h);
      send_raw(o, a, l, h);
      m_apply();
      wait_idle();
   endtask

   task automatic check_writes(string req);
      chk({req, " write count"}, gq_a.size(), eq_a.size());
      for (int i = 0; i < eq_a.size() && i < gq_a.size(); i++) begin
         chk({req, " write addr"}, gq_a[i], eq_a[i]);
         chk({req, " write data"}, gq_d[i], eq_d[i]);
      end
      eq_a.delete(); eq_d.delete(); gq_a.delete(); gq_d.delete();
   endtask

   task automatic check_state(string req);
      chk({req, " status"}, stat, exp_stat(1'b0));
      cs_n = 1'b0;
      #1;
      chk({req, " so_oe"}, so_oe, m_rb && m_mode);
      if (so_oe) chk({req, " so ready"}, so, 1'b1);
      cs_n = 1'b1;
      #1;
      chk({req, " so float"}, so_oe, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 status at reset", stat, 8'h00);
      chk("R1 no write at reset", we, 1'b0);
      chk("R1 so not driven", so_oe, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 entry without write enable is ignored
      send(8'hAD, 24'h000100, 8'h11, 8'h22);
      check_writes("R2 entry w/o WEL");
      chk("R2 mode off", stat, 8'h00);
      send(8'h06, 0, 0, 0);
      chk("R2 WEL set", stat, 8'h02);
      send(8'h04, 0, 0, 0);
      chk("R2 WEL cleared", stat, 8'h00);

      // R12 enable ready/busy, then enter, R3 / R5 timing
      send(8'h70, 0, 0, 0);
      send(8'h06, 0, 0, 0);
      send_raw(8'hAD, 24'h000201, 8'hA1, 8'hB2);
      m_apply();
      chk("R3 low byte in first cycle", {we, waddr}, {1'b1, 24'h000200});
      chk("R3 low byte data", wdata, 8'hA1);
      chk("R2 mode bit set on entry", stat[6], 1'b1);
      cs_n = 1'b0;
      #1;
      chk("R12 so driven while busy", so_oe, 1'b1);
      chk("R12 so busy level", so, 1'b0);
      cs_n = 1'b1;
      begin
         int bad = 0;
         for (int i = 1; i < BC + 5; i++) begin
            @(negedge clk);
            if (i == 1) chk("R3 high byte second cycle", {we, waddr, wdata}, {1'b1, 24'h000201, 8'hB2});
            if (stat[0] !== (i < BC + 2)) bad++;
         end
         chk("R5 busy window length", bad, 0);
      end
      check_writes("R3 entry word");
      check_state("R12 ready after word");

      // R4 continuation ignores its address field
      send(8'hAD, 24'h00ABCD, 8'h33, 8'h44);
      check_writes("R4 continuation");
      // R6 command while busy dropped
      send_raw(8'hAD, 0, 8'h55, 8'h66);
      m_apply();
      send_raw(8'h04, 0, 0, 0);
      wait_idle();
      check_writes("R6 busy drop writes");
      chk("R6 mode kept after dropped disable", stat, exp_stat(1'b0));
      // R7 ignored opcodes in the mode
      send(8'h80, 0, 0, 0);
      send(8'h06, 0, 0, 0);
      send(8'h20, 0, 0, 0);
      check_writes("R7 ignored ops");
      check_state("R7 ready/busy still on");
      // R8 disable ends the mode
      send(8'h04, 0, 0, 0);
      chk("R8 mode and WEL cleared", stat, 8'h00);
      send(8'hAD, 24'h000300, 8'h77, 8'h88);
      check_writes("R8 no write after disable");

      // R9 exit below the protection bound
      pb = 25'h0001000;
      send(8'h06, 0, 0, 0);
      send(8'hAD, 24'h000FFC, 8'h01, 8'h02);
      chk("R9 still in mode", stat, 8'h42);
      send(8'hAD, 0, 8'h03, 8'h04);
      chk("R9 auto exit", stat, 8'h00);
      send(8'hAD, 0, 8'h05, 8'h06);
      check_writes("R9 exit at bound");
      // R10 entry in protected region
      send(8'h06, 0, 0, 0);
      send(8'hAD, 24'h001000, 8'h07, 8'h08);
      chk("R10 entry ignored", stat, 8'h02);
      check_writes("R10 no write");
      // R11 odd bound: low byte written, high suppressed
      pb = 25'h0002001;
      send(8'hAD, 24'h002000, 8'h09, 8'h0A);
      check_writes("R11 partial word");
      chk("R11 exit after partial word", stat, 8'h00);
      // R9 top of address space, no wrap
      pb = PB_NONE;
      send(8'h06, 0, 0, 0);
      send(8'hAD, 24'hFFFFFD, 8'h0B, 8'h0C);
      send(8'hAD, 0, 8'h0D, 8'h0E);
      chk("R9 exit at top", stat, 8'h00);
      send(8'hAD, 0, 8'h0F, 8'h10);
      check_writes("R9 no wrap");
      send(8'h80, 0, 0, 0);
      check_state("R12 disabled");

      // random mix
      for (int it = 0; it < 300; it++) begin
         logic [7:0] ops [9] = '{8'hAD, 8'hAD, 8'hAD, 8'h04, 8'h06, 8'h05, 8'h70, 8'h80, 8'h20};
         logic [7:0] o;
         logic [AW:0] a;
         if (!m_mode && ($urandom % 8 == 0)) begin
            case ($urandom % 4)
               0: pb = PB_NONE;
               1: pb = 25'h0040000;
               2: pb = 25'h0080001;
               default: pb = 25'h0000F00;
            endcase
         end
         o = ops[$urandom % 9];
         if ($urandom % 2 == 1) a = pb - 25'($urandom % 12);
         else a = 25'($urandom) % pb;
         send(o, a[AW-1:0], 8'($urandom), 8'($urandom));
         check_writes("R4 random writes");
         check_state("R7 random state");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule